// File: doc/BRIEF.md
# I2C Write-Only Register Slave with Set-Length Commit

This block is an I2C target that only accepts write transfers into an internal coefficient and register space. It watches SCL and SDA, which must already be synchronized to the system clock. It recognises START, repeated START and STOP conditions and matches its own device address. It pulls SDA low through `sda_oe` to acknowledge. The first byte after the address selects a subaddress. The data bytes that follow are gathered into a wide buffer.

Each subaddress belongs to a class, and the class fixes how many bytes make a complete set. Nothing leaves the block until a set is complete. At that point a single-cycle strobe presents the subaddress, the whole set and its length in words to the register file outside the block. The subaddress then steps forward, so one burst can fill several consecutive locations. If the transfer stops part way through a set, that set is thrown away. Sets completed earlier in the same burst stay written.

Top module: `i2c_wr_slave`

## Requirements
- R1: An address byte of 0x36 (7-bit address 0x1B, R/W bit 0) is acknowledged: SDA is held low for the whole ninth SCL clock.
- R2: An address byte with any other 7-bit address gets no acknowledge. No later byte is acknowledged and nothing is committed until the next START.
- R3: An address byte of 0x37 (own address, R/W bit 1) is acknowledged. After that, SDA stays released and nothing is committed until the next START or STOP.
- R4: After a matching write address, the subaddress byte and every data byte are acknowledged, including bytes that are later discarded.
- R5: Subaddresses 0x51 to 0x7F need 20 bytes and commit with `wr_len` = 5. Every other subaddress needs 4 bytes and commits with `wr_len` = 1.
- R6: `wr_en` is high for exactly one cycle. That cycle is the one after the SCL falling edge that ends the acknowledge of a set's last byte.
- R7: A set still incomplete when a STOP or repeated START arrives produces no commit.
- R8: After each commit the subaddress advances by one, wrapping from 0xFF to 0x00. Commits made before a discarded tail in the same burst stand.
- R9: START and STOP are recognised in every state, including in the middle of a byte. After a STOP, `sda_oe` is low from the next cycle on.
- R10: Bits arrive MSB first and are sampled on the SCL rising edge. `wr_data` holds the set's bytes in arrival order: the last byte is in `wr_data[7:0]`, and bits above the set's width are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| wr_en | output | 1 | One-cycle commit strobe |
| wr_addr | output | 8 | Subaddress of the committed set |
| wr_data | output | 160 | Committed bytes, last byte in bits 7:0 |
| wr_len | output | 3 | Committed length in 32-bit words |

## Verification
The bench builds the block with its default parameters. These are device address 0x1B, a long class spanning subaddresses 0x51 to 0x7F, 4-byte words, 5-word long sets and 1-word short sets. With these values both set lengths fall inside bursts of a few dozen bytes. The same defaults also make reachable both edges of the long-class range, the short-class wrap from 0xFF to 0x00, and a long set that starts near the top of its range and runs into short subaddresses.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_SUB  = 3'd2,
        ST_DATA = 3'd3,
        ST_SKIP = 3'd4
    } wr_state_e;

endpackage

// File: rtl/i2c_wr_edge.sv
module i2c_wr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d.scl = scl_i;
        line_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '{scl: 1'b1, sda: 1'b1};
        else        line_q <= line_d;
    end

    assign scl_rise  = !line_q.scl && scl_i;
    assign scl_fall  = line_q.scl && !scl_i;
    assign start_det = line_q.scl && scl_i && line_q.sda && !sda_i;
    assign stop_det  = line_q.scl && scl_i && !line_q.sda && sda_i;

endmodule

// File: rtl/i2c_wr_len.sv
module i2c_wr_len #(
    parameter logic [7:0] LONG_LO     = 8'h51,
    parameter logic [7:0] LONG_HI     = 8'h7F,
    parameter int         LONG_WORDS  = 5,
    parameter int         SHORT_WORDS = 1,
    parameter int         LEN_W       = 3
) (
    input  logic [7:0]       sub_i,
    output logic [LEN_W-1:0] words_o
);

    always_comb begin
        if (sub_i >= LONG_LO && sub_i <= LONG_HI) words_o = LEN_W'(LONG_WORDS);
        else                                      words_o = LEN_W'(SHORT_WORDS);
    end

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import i2c_wr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h1B,
    parameter int         WORD_BYTES  = 4,
    parameter int         SHORT_WORDS = 1,
    parameter int         DATA_W      = 160,
    parameter int         LEN_W       = 3,
    parameter int         CNT_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [LEN_W-1:0]  need_words,
    output logic [7:0]        sub_o,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [7:0]        wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [LEN_W-1:0]  wr_len
);

    localparam int SHORT_BITS = SHORT_WORDS * WORD_BYTES * 8;

    typedef struct packed {
        wr_state_e         state;
        logic [3:0]        bitcnt;
        logic              ack_ph;
        logic              oe;
        logic [7:0]        shreg;
        logic [7:0]        sub;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] acc;
        logic              we;
        logic [7:0]        waddr;
        logic [DATA_W-1:0] wdata;
        logic [LEN_W-1:0]  wlen;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [CNT_W-1:0]  need_bytes;
    logic [DATA_W-1:0] acc_nx;

    assign need_bytes = CNT_W'(need_words * WORD_BYTES);
    assign acc_nx     = {fsm_q.acc[DATA_W-9:0], fsm_q.shreg};

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.we = 1'b0;
        if (start_det || stop_det) begin
            fsm_d.state  = start_det ? ST_ADDR : ST_IDLE;
            fsm_d.bitcnt = '0;
            fsm_d.ack_ph = 1'b0;
            fsm_d.oe     = 1'b0;
            fsm_d.cnt    = '0;
            fsm_d.acc    = '0;
        end else if (fsm_q.state == ST_ADDR || fsm_q.state == ST_SUB ||
                     fsm_q.state == ST_DATA) begin
            if (scl_rise && !fsm_q.ack_ph && fsm_q.bitcnt < 4'd8) begin
                fsm_d.shreg  = {fsm_q.shreg[6:0], sda_i};
                fsm_d.bitcnt = fsm_q.bitcnt + 4'd1;
            end else if (scl_fall && !fsm_q.ack_ph && fsm_q.bitcnt == 4'd8) begin
                fsm_d.ack_ph = 1'b1;
                fsm_d.oe     = (fsm_q.state != ST_ADDR) ||
                               (fsm_q.shreg[7:1] == DEV_ADDR);
            end else if (scl_fall && fsm_q.ack_ph) begin
                fsm_d.ack_ph = 1'b0;
                fsm_d.oe     = 1'b0;
                fsm_d.bitcnt = '0;
                case (fsm_q.state)
                    ST_ADDR: begin
                        if (fsm_q.shreg[7:1] != DEV_ADDR) fsm_d.state = ST_IDLE;
                        else if (fsm_q.shreg[0])          fsm_d.state = ST_SKIP;
                        else                              fsm_d.state = ST_SUB;
                    end
                    ST_SUB: begin
                        fsm_d.sub   = fsm_q.shreg;
                        fsm_d.cnt   = '0;
                        fsm_d.acc   = '0;
                        fsm_d.state = ST_DATA;
                    end
                    default: begin
                        if (fsm_q.cnt + 1'b1 == need_bytes) begin
                            fsm_d.we    = 1'b1;
                            fsm_d.waddr = fsm_q.sub;
                            fsm_d.wdata = acc_nx;
                            fsm_d.wlen  = need_words;
                            fsm_d.sub   = fsm_q.sub + 8'd1;
                            fsm_d.cnt   = '0;
                            fsm_d.acc   = '0;
                        end else begin
                            fsm_d.acc = acc_nx;
                            fsm_d.cnt = fsm_q.cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '0;
        else        fsm_q <= fsm_d;
    end

    assign sub_o   = fsm_q.sub;
    assign sda_oe  = fsm_q.oe;
    assign wr_en   = fsm_q.we;
    assign wr_addr = fsm_q.waddr;
    assign wr_data = fsm_q.wdata;
    assign wr_len  = fsm_q.wlen;

    // R6
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.we |=> !fsm_q.we);

    // R6
    wr_at_ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.we |-> $past(scl_fall));

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !fsm_q.oe);

    // R1
    ack_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsm_q.oe) |-> $past(scl_fall));

    // R10
    short_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.we && fsm_q.wlen == LEN_W'(SHORT_WORDS)) |->
        fsm_q.wdata[DATA_W-1:SHORT_BITS] == '0);

endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h1B,
    parameter logic [7:0] LONG_LO     = 8'h51,
    parameter logic [7:0] LONG_HI     = 8'h7F,
    parameter int         WORD_BYTES  = 4,
    parameter int         LONG_WORDS  = 5,
    parameter int         SHORT_WORDS = 1,
    localparam int        DATA_W      = LONG_WORDS * WORD_BYTES * 8,
    localparam int        LEN_W       = $clog2(LONG_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [7:0]        wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [LEN_W-1:0]  wr_len
);

    localparam int CNT_W = $clog2(LONG_WORDS * WORD_BYTES + 1);

    logic             scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]       cur_sub;
    logic [LEN_W-1:0] need_words;

    i2c_wr_edge i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_wr_len #(
        .LONG_LO     (LONG_LO),
        .LONG_HI     (LONG_HI),
        .LONG_WORDS  (LONG_WORDS),
        .SHORT_WORDS (SHORT_WORDS),
        .LEN_W       (LEN_W)
    ) i_len (
        .sub_i   (cur_sub),
        .words_o (need_words)
    );

    i2c_wr_fsm #(
        .DEV_ADDR    (DEV_ADDR),
        .WORD_BYTES  (WORD_BYTES),
        .SHORT_WORDS (SHORT_WORDS),
        .DATA_W      (DATA_W),
        .LEN_W       (LEN_W),
        .CNT_W       (CNT_W)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_i),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .need_words (need_words),
        .sub_o      (cur_sub),
        .sda_oe     (sda_oe),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_len     (wr_len)
    );

endmodule

// File: tb/test_i2c_wr_slave.sv
module test_i2c_wr_slave;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_drv = 1'b1;
    logic         sda_drv = 1'b1;
    logic         sda_bus;
    logic         sda_oe, wr_en;
    logic [7:0]   wr_addr;
    logic [159:0] wr_data;
    logic [2:0]   wr_len;

    int n_chk = 0;
    int n_fail = 0;
    int exp_pulses = 0;
    int obs_pulses = 0;
    logic [7:0] dq [0:63];

    assign sda_bus = sda_drv & ~sda_oe;

    always #5 clk = ~clk;

    i2c_wr_slave i_i2c_wr_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_drv),
        .sda_i   (sda_bus),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_len  (wr_len)
    );

    always @(negedge clk) if (rst_n && wr_en) obs_pulses++;

    function automatic int need_of(input logic [7:0] s);
        return (s >= 8'h51 && s <= 8'h7F) ? 20 : 4;
    endfunction

    task automatic check(input bit ok, input string req, input logic [159:0] act,
                         input logic [159:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic i2c_start();
        @(negedge clk) sda_drv = 1'b1;
        repeat (2) @(negedge clk);
        scl_drv = 1'b1;
        repeat (3) @(negedge clk);
        sda_drv = 1'b0;
        repeat (3) @(negedge clk);
        scl_drv = 1'b0;
    endtask

    task automatic i2c_stop();
        @(negedge clk) sda_drv = 1'b0;
        repeat (2) @(negedge clk);
        scl_drv = 1'b1;
        repeat (3) @(negedge clk);
        sda_drv = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk) sda_drv = b[7-i];
            repeat (2) @(negedge clk);
            scl_drv = 1'b1;
            repeat (3) @(negedge clk);
            scl_drv = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked, output bit we);
        send_bits(b, 8);
        @(negedge clk) sda_drv = 1'b1;
        repeat (2) @(negedge clk);
        scl_drv = 1'b1;
        repeat (2) @(negedge clk);
        acked = !sda_bus;
        @(negedge clk) scl_drv = 1'b0;
        @(negedge clk) we = wr_en;
    endtask

    task automatic run_write(input logic [7:0] abyte, input logic [7:0] sub,
                             input int n, input bit do_stop);
        bit a, we, match, wok;
        logic [7:0] s;
        int c;
        logic [159:0] acc;
        string tag;
        match = (abyte[7:1] == 7'h1B);
        wok   = match && !abyte[0];
        tag   = !match ? "R2" : (abyte[0] ? "R3" : "R1");
        i2c_start();
        send_byte(abyte, a, we);
        check(a == match, tag, 160'(a), 160'(match));
        send_byte(sub, a, we);
        check(a == wok, wok ? "R4" : "R3", 160'(a), 160'(wok));
        s = sub; c = 0; acc = '0;
        for (int i = 0; i < n; i++) begin
            send_byte(dq[i], a, we);
            check(a == wok, wok ? "R4" : "R2", 160'(a), 160'(wok));
            if (wok) begin
                acc = {acc[151:0], dq[i]};
                c++;
                if (c == need_of(s)) begin
                    check(we == 1'b1, "R6", 160'(we), 160'(1));
                    check(wr_addr == s, "R8", 160'(wr_addr), 160'(s));
                    check(wr_data == acc, "R10", wr_data, acc);
                    check(int'(wr_len) == need_of(s) / 4, "R5", 160'(wr_len),
                          160'(need_of(s) / 4));
                    exp_pulses++;
                    s = s + 8'd1; c = 0; acc = '0;
                end else begin
                    check(we == 1'b0, "R7", 160'(we), 160'(0));
                end
            end else begin
                check(we == 1'b0, "R2", 160'(we), 160'(0));
            end
        end
        if (do_stop) begin
            i2c_stop();
            check(sda_oe == 1'b0, "R9", 160'(sda_oe), 160'(0));
        end
        check(obs_pulses == exp_pulses, "R7", 160'(obs_pulses), 160'(exp_pulses));
    endtask

    task automatic finish_tb();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog act=running exp=done");
        finish_tb();
    end

    initial begin
        bit a, we;
        void'($urandom(32'd7321));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sda_oe == 1'b0, "R9", 160'(sda_oe), 160'(0));
        check(wr_en == 1'b0, "R6", 160'(wr_en), 160'(0));

        for (int k = 0; k < 64; k++) dq[k] = 8'(k * 37 + 5);
        // R5 short class, single word
        run_write(8'h36, 8'h00, 4, 1'b1);
        // R5 long-class lower edge and last short below it
        run_write(8'h36, 8'h50, 4, 1'b1);
        run_write(8'h36, 8'h51, 20, 1'b1);
        // R5 upper edge, then first short above it in one burst (R8)
        run_write(8'h36, 8'h7F, 24, 1'b1);
        // R8 wrap 0xFF -> 0x00 with a discarded 3-byte tail (R7)
        run_write(8'h36, 8'hFF, 11, 1'b1);
        // R2 foreign address, R3 read direction
        run_write(8'h34, 8'h10, 4, 1'b1);
        run_write(8'h37, 8'h10, 4, 1'b1);
        // R7 repeated START mid-set, then a clean set after it
        run_write(8'h36, 8'h60, 7, 1'b0);
        run_write(8'h36, 8'h20, 4, 1'b1);
        // R9 STOP in the middle of a byte
        i2c_start();
        send_byte(8'h36, a, we);
        send_byte(8'h10, a, we);
        send_byte(8'hAA, a, we);
        send_bits(8'hA5, 3);
        i2c_stop();
        check(sda_oe == 1'b0, "R9", 160'(sda_oe), 160'(0));
        check(obs_pulses == exp_pulses, "R9", 160'(obs_pulses), 160'(exp_pulses));
        run_write(8'h36, 8'h10, 4, 1'b1);

        for (int t = 0; t < 16; t++) begin
            int unsigned pick;
            logic [7:0] sb, ab;
            int nb;
            pick = $urandom % 4;
            case (pick)
                0: sb = 8'(8'h51 + ($urandom % 47));
                1: sb = 8'($urandom);
                2: sb = 8'(8'hFE + ($urandom % 2));
                default: sb = 8'(8'h4E + ($urandom % 4));
            endcase
            nb = $urandom % 45;
            for (int k = 0; k < nb; k++) dq[k] = 8'($urandom);
            ab = (($urandom % 8) == 0) ? 8'h34 : 8'h36;
            run_write(ab, sb, nb, ($urandom % 3) != 0);
        end
        i2c_stop();
        repeat (3) @(negedge clk);
        check(obs_pulses == exp_pulses, "R7", 160'(obs_pulses), 160'(exp_pulses));
        finish_tb();
    end

endmodule